// File: doc/BRIEF.md
# Nine-Bit Panel Command Transmitter

This block is a transmit-only serial master for display panels that take 9-bit words. The top bit of every word tells the panel whether the remaining eight bits are a register address (flag clear) or a parameter byte (flag set). One request names a register address and carries zero, one or two parameter bytes. The block turns it into one, two or three words and shifts them out on a serial clock and data line. Chip select stays low across all the words of that request.

The serial clock idles high. Data changes on the falling edge and the panel samples it on the rising edge. Words go out flag bit first, then the byte from its most significant bit down. The half period of the serial clock is a whole number of system clocks, set by a parameter. Chip select has a half-period margin on each side of the clocking. Back-to-back requests are separated by at least one full serial clock period of idle bus. A request that asks for more than two parameter bytes is refused with a one-cycle error pulse.

Top module: `nine_bit_spi_tx`

## Requirements
- R1: Out of reset and whenever no request is in progress, csN, sclk and mosi are all high, and busy, done and reqError are low.
- R2: While chip select is low, mosi changes only while sclk is low; it holds steady for the whole of every high phase of sclk, so each bit is stable at its rising edge.
- R3: Each word is 9 bits sent most significant bit first. Bit 8 is 0 for the address word and 1 for a parameter word, and bits 7..0 carry the byte.
- R4: A request with reqCount = 0 produces exactly 9 rising edges of sclk, carrying {0, reqAddr}.
- R5: A request with reqCount = 1 produces 18 rising edges: the address word, then {1, reqData[7:0]}.
- R6: A request with reqCount = 2 produces 27 rising edges: the address word, then {1, reqData[15:8]}, then {1, reqData[7:0]}.
- R7: csN stays low from before the first falling edge of sclk until after the last rising edge. At least HALF_DIV system clocks separate the fall of csN from the first sclk fall, and the last sclk rise from the rise of csN.
- R8: Between the rise of csN and the next fall of csN there are at least 2*HALF_DIV system clocks.
- R9: A request with reqCount = 3 is refused. reqError is high for exactly the one cycle after it, busy stays low and csN does not fall.
- R10: busy rises in the cycle after a request is accepted and stays high until done. done is high for a single cycle, and busy is already low in that cycle.
- R11: Every low phase of sclk lasts exactly HALF_DIV system clocks.
- R12: reqValid is ignored while busy is high: no error pulse and no change to the words already being sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe, taken when the block is idle |
| reqAddr | input | 8 | Register address for the command word |
| reqCount | input | 2 | Number of parameter bytes (0 to 2; 3 is refused) |
| reqData | input | 16 | Parameter bytes; [15:8] first when two are sent, [7:0] when one |
| busy | output | 1 | High from acceptance until done |
| done | output | 1 | One-cycle pulse at the end of a transaction |
| reqError | output | 1 | One-cycle pulse when a request is refused |
| sclk | output | 1 | Serial clock, idle high |
| mosi | output | 1 | Serial data, idle high |
| csN | output | 1 | Active-low chip select |

## Verification
The bench sweeps every byte count, including the refused value 3, against addresses and data at both extremes and in mixed patterns. It decodes the bus independently on each rising edge. A byte-order slip would swap the two parameter words of a three-word frame, and an off-by-one in the bit counter would show up as 8 or 10 clocks per word. A refused request that leaked through would drop chip select. The margins at the edges of chip select, the inter-frame gap and the length of each low phase are timed in system clocks, so a design that released chip select on the last rising edge, or started a new frame at once, would be reported. A stray request injected mid-frame would corrupt the frame or pulse the error if the busy gating were missing.

// File: rtl/nine_spi_pkg.sv
package nine_spi_pkg;
  localparam int BYTE_W    = 8;
  localparam int WORD_W    = BYTE_W + 1;
  localparam int MAX_BYTES = 2;
  localparam int FRAME_W   = WORD_W * (MAX_BYTES + 1);
  localparam int CNT_W     = 2;
  localparam int BIT_CNT_W = $clog2(FRAME_W);

  typedef enum logic [2:0] {
    ST_IDLE, ST_LEAD, ST_LOW, ST_HIGH, ST_TRAIL, ST_GAP1, ST_GAP2
  } ctrlState_t;

  typedef struct packed {
    logic load;
    logic shift;
    logic sclkFall;
    logic sclkRise;
    logic csAssert;
    logic csRelease;
  } spiStrobe_t;
endpackage

// File: rtl/nspi_datapath.sv
module nspi_datapath
  import nine_spi_pkg::*;
#(
  parameter int HALF_DIV = 4
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  spiStrobe_t                strobe,
  input  logic                      run,
  input  logic [BYTE_W-1:0]         reqAddr,
  input  logic [CNT_W-1:0]          reqCount,
  input  logic [2*BYTE_W-1:0]       reqData,
  output logic                      halfTick,
  output logic                      sclk,
  output logic                      csN,
  output logic                      mosi
);
  localparam int DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic [DIV_W-1:0]   divCnt;
  logic [FRAME_W-1:0] shiftReg;
  logic [FRAME_W-1:0] frameNext;
  logic [WORD_W-1:0]  cmdWord, hiWord, loWord;

  // half-period tick generator
  always_ff @(posedge clk) begin
    if (!rstN || !run)                       divCnt <= '0;
    else if (divCnt == DIV_W'(HALF_DIV - 1)) divCnt <= '0;
    else                                     divCnt <= divCnt + 1'b1;
  end
  assign halfTick = run && (divCnt == DIV_W'(HALF_DIV - 1));

  // frame assembly: address word leads, parameter words follow
  assign cmdWord = {1'b0, reqAddr};
  assign hiWord  = {1'b1, reqData[2*BYTE_W-1:BYTE_W]};
  assign loWord  = {1'b1, reqData[BYTE_W-1:0]};
  always_comb begin
    if (reqCount == CNT_W'(MAX_BYTES)) frameNext = {cmdWord, hiWord, loWord};
    else                               frameNext = {cmdWord, loWord, {WORD_W{1'b0}}};
  end

  always_ff @(posedge clk) begin
    if (!rstN)             shiftReg <= '0;
    else if (strobe.load)  shiftReg <= frameNext;
    else if (strobe.shift) shiftReg <= {shiftReg[FRAME_W-2:0], 1'b0};
  end

  always_ff @(posedge clk) begin
    if (!rstN)                 sclk <= 1'b1;
    else if (strobe.sclkFall)  sclk <= 1'b0;
    else if (strobe.sclkRise)  sclk <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                 csN <= 1'b1;
    else if (strobe.csAssert)  csN <= 1'b0;
    else if (strobe.csRelease) csN <= 1'b1;
  end

  assign mosi = csN ? 1'b1 : shiftReg[FRAME_W-1];

  // R1: idle bus levels
  p_idle_high_r1: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> (sclk && mosi));
  // R2: data held through every high phase
  p_mosi_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!csN && !$past(csN) && sclk && $past(sclk)) |-> $stable(mosi));
  // R7: clocking only under chip select
  p_clk_in_frame_r7: assert property (@(posedge clk) disable iff (!rstN)
    !sclk |-> !csN);
endmodule

// File: rtl/nspi_control.sv
module nspi_control
  import nine_spi_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [CNT_W-1:0] reqCount,
  input  logic             halfTick,
  output spiStrobe_t       strobe,
  output logic             run,
  output logic             busy,
  output logic             done,
  output logic             reqError
);
  ctrlState_t           state, stateNext;
  logic [BIT_CNT_W-1:0] bitsLeft;
  logic [BIT_CNT_W-1:0] lastIdx;
  logic                 countOk;

  assign countOk = (reqCount <= CNT_W'(MAX_BYTES));
  assign lastIdx = BIT_CNT_W'(WORD_W * (int'(reqCount) + 1) - 1);

  always_comb begin
    strobe    = '0;
    stateNext = state;
    unique case (state)
      ST_IDLE: if (reqValid && countOk) begin
        strobe.load     = 1'b1;
        strobe.csAssert = 1'b1;
        stateNext       = ST_LEAD;
      end
      ST_LEAD: if (halfTick) begin
        strobe.sclkFall = 1'b1;
        stateNext       = ST_LOW;
      end
      ST_LOW: if (halfTick) begin
        strobe.sclkRise = 1'b1;
        stateNext       = ST_HIGH;
      end
      ST_HIGH: if (halfTick) begin
        if (bitsLeft == '0) stateNext = ST_TRAIL;
        else begin
          strobe.shift    = 1'b1;
          strobe.sclkFall = 1'b1;
          stateNext       = ST_LOW;
        end
      end
      ST_TRAIL: if (halfTick) begin
        strobe.csRelease = 1'b1;
        stateNext        = ST_GAP1;
      end
      ST_GAP1: if (halfTick) stateNext = ST_GAP2;
      ST_GAP2: if (halfTick) stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      bitsLeft <= '0;
      done     <= 1'b0;
      reqError <= 1'b0;
    end else begin
      state    <= stateNext;
      done     <= (state == ST_GAP2) && halfTick;
      reqError <= (state == ST_IDLE) && reqValid && !countOk;
      if (strobe.load)       bitsLeft <= lastIdx;
      else if (strobe.shift) bitsLeft <= bitsLeft - 1'b1;
    end
  end

  assign busy = (state != ST_IDLE);
  assign run  = busy;

  // R10: done is a single pulse with busy already low
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  p_done_idle_r10: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);
  // R9: a refused request never starts a frame
  p_err_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    reqError |-> !busy);
  // R4: bit counter stays inside the frame
  p_bits_bound_r4: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (bitsLeft < BIT_CNT_W'(FRAME_W)));
endmodule

// File: rtl/nine_bit_spi_tx.sv
module nine_bit_spi_tx
  import nine_spi_pkg::*;
#(
  parameter int HALF_DIV = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic [7:0]  reqAddr,
  input  logic [1:0]  reqCount,
  input  logic [15:0] reqData,
  output logic        busy,
  output logic        done,
  output logic        reqError,
  output logic        sclk,
  output logic        mosi,
  output logic        csN
);
  spiStrobe_t strobe;
  logic       halfTick;
  logic       run;

  nspi_control u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqCount(reqCount),
    .halfTick(halfTick), .strobe(strobe), .run(run), .busy(busy),
    .done(done), .reqError(reqError)
  );

  nspi_datapath #(.HALF_DIV(HALF_DIV)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .run(run), .reqAddr(reqAddr),
    .reqCount(reqCount), .reqData(reqData), .halfTick(halfTick),
    .sclk(sclk), .csN(csN), .mosi(mosi)
  );
endmodule

// File: tb/tb_nine_bit_spi_tx.sv
module tb_nine_bit_spi_tx;
  localparam int HALF = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [7:0]  reqAddr = '0;
  logic [1:0]  reqCount = '0;
  logic [15:0] reqData = '0;
  logic busy, done, reqError, sclk, mosi, csN;

  nine_bit_spi_tx #(.HALF_DIV(HALF)) dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqCount(reqCount), .reqData(reqData), .busy(busy), .done(done),
    .reqError(reqError), .sclk(sclk), .mosi(mosi), .csN(csN)
  );

  always #10 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // bus monitor, sampled away from the active edge
  logic [26:0] cap;
  int nBits, csFalls, gapBad;
  int csFallCyc, csRiseCyc, lastFallCyc, lastRiseCyc;
  bit firstFall, seenRise, leadBad, phaseBad, holdBad, trailOk;
  logic prevCs = 1'b1, prevSclk = 1'b1, prevMosi = 1'b1;
  initial begin
    cap = '0; nBits = 0; csFalls = 0; gapBad = 0; csFallCyc = 0; csRiseCyc = 0;
    lastFallCyc = 0; lastRiseCyc = 0; firstFall = 0; seenRise = 0;
    leadBad = 0; phaseBad = 0; holdBad = 0; trailOk = 0;
  end

  always @(negedge clk) if (rstN) begin
    if (prevCs && !csN) begin
      csFalls++;
      if (seenRise && (cyc - csRiseCyc < 2*HALF)) gapBad++;
      cap = '0; nBits = 0; firstFall = 1; csFallCyc = cyc;
      leadBad = 0; phaseBad = 0; holdBad = 0; trailOk = 0;
    end
    if (!csN && prevSclk && !sclk) begin
      if (firstFall) begin
        if (cyc - csFallCyc < HALF) leadBad = 1;
        firstFall = 0;
      end
      lastFallCyc = cyc;
    end
    if (!csN && !prevSclk && sclk) begin
      cap = {cap[25:0], mosi};
      nBits++;
      if (cyc - lastFallCyc != HALF) phaseBad = 1;
      lastRiseCyc = cyc;
    end
    if (!csN && !prevCs && prevSclk && sclk && (mosi != prevMosi)) holdBad = 1;
    if (!prevCs && csN) begin
      trailOk = (cyc - lastRiseCyc >= HALF);
      csRiseCyc = cyc;
      seenRise = 1;
    end
    prevCs = csN; prevSclk = sclk; prevMosi = mosi;
  end

  function automatic int expFrame(input logic [7:0] a, input int n, input logic [15:0] d);
    int f;
    f = int'(a);
    if (n == 1) f = f * 512 + 256 + int'(d[7:0]);
    if (n == 2) begin
      f = f * 512 + 256 + int'(d[15:8]);
      f = f * 512 + 256 + int'(d[7:0]);
    end
    return f;
  endfunction

  task automatic runTxn(input logic [7:0] a, input int n, input logic [15:0] d,
                        input bit inject);
    int fallsBefore;
    string tag;
    fallsBefore = csFalls;
    @(negedge clk);
    reqValid = 1'b1; reqAddr = a; reqCount = 2'(n); reqData = d;
    @(negedge clk);
    reqValid = 1'b0;
    if (n == 3) begin
      check(reqError == 1'b1, "R9 error pulse", 32'(reqError), 1);
      check(busy == 1'b0, "R9 busy stays low", 32'(busy), 0);
      @(negedge clk);
      check(reqError == 1'b0, "R9 error one cycle", 32'(reqError), 0);
      repeat (4*HALF) @(negedge clk);
      check(csFalls == fallsBefore && csN, "R9 no bus activity",
            32'(csFalls - fallsBefore), 0);
      return;
    end
    check(busy == 1'b1, "R10 busy after accept", 32'(busy), 1);
    if (inject) begin
      repeat (5*HALF) @(negedge clk);
      reqValid = 1'b1; reqAddr = ~a; reqCount = 2'd3; reqData = ~d;
      @(negedge clk);
      reqValid = 1'b0;
      @(negedge clk);
      check(reqError == 1'b0, "R12 no error while busy", 32'(reqError), 0);
      reqValid = 1'b1; reqCount = 2'd2;
      @(negedge clk);
      reqValid = 1'b0;
    end
    while (!done) @(negedge clk);
    check(busy == 1'b0, "R10 busy low at done", 32'(busy), 0);
    tag = (n == 0) ? "R4" : (n == 1) ? "R5" : "R6";
    check(nBits == 9*(n+1), {tag, " bit count"}, 32'(nBits), 32'(9*(n+1)));
    check(int'(cap) == expFrame(a, n, d), {tag, " R3 frame content", inject ? " R12" : ""},
          32'(cap), 32'(expFrame(a, n, d)));
    check(!leadBad && trailOk, "R7 chip select margins", {30'd0, leadBad, trailOk}, 1);
    check(!phaseBad, "R11 low phase length", 32'(phaseBad), 0);
    check(!holdBad, "R2 data stable while sclk high", 32'(holdBad), 0);
    @(negedge clk);
    check(done == 1'b0, "R10 done single cycle", 32'(done), 0);
    check(csN && sclk && mosi, "R1 idle levels after frame", {29'd0, csN, sclk, mosi}, 7);
  endtask

  initial begin
    wait (cyc == 100000);
    fails++;
    $display("FAIL watchdog R10 actual=busy expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(csN && sclk && mosi, "R1 reset bus levels", {29'd0, csN, sclk, mosi}, 7);
    check(!busy && !done && !reqError, "R1 reset flags", {29'd0, busy, done, reqError}, 0);
    for (int n = 0; n < 4; n++) begin
      for (int k = 0; k < 6; k++) begin
        logic [7:0] a;
        logic [15:0] d;
        a = (k == 0) ? 8'h00 : (k == 1) ? 8'hFF : 8'(k * 53 + n * 7);
        d = (k == 0) ? 16'hFFFF : (k == 1) ? 16'h0000 : {~a, 8'(a + 8'(k))};
        runTxn(a, n, d, 1'b0);
      end
    end
    runTxn(8'hB8, 2, 16'hFFF9, 1'b1);
    runTxn(8'h3A, 1, 16'h0060, 1'b1);
    runTxn(8'h29, 0, 16'h1234, 1'b0);
    check(gapBad == 0, "R8 idle gap between frames", 32'(gapBad), 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule